// File: doc/BRIEF.md
# Vowel Peak Code Generator

This block turns a stream of signed audio samples into a short stream of symbols, one per waveform peak. A sample counts only in a cycle where its strobe is high. A positive peak is the last sample of a rise before the waveform turns down. A negative peak is the mirror case. Either kind counts only if it lies beyond a programmable noise threshold.

For each peak the block emits a symbol with four parts:
- the peak polarity;
- whether its magnitude grew or shrank against the previous peak of the same polarity;
- a saturating count of the samples since the last peak;
- a one-cycle valid pulse.

Sustained vowels are periodic, so they give a repeating pattern of these symbols.

A small matcher keeps the two-bit form ({polarity, grew}) of the most recent symbols in a window. It compares the window with a parameter set of reference sequences. When the window equals one of them, it reports the index of that reference. A long stretch without peaks saturates the interval counter and empties the window, so separate utterances never run together in one match.

Top module: `vowel_peak_coder`

## Requirements
- R1: A positive peak is declared on a valid sample x when all three hold: x is lower than the stored predecessor p; the last unequal step into p was upward (equal steps keep the earlier direction); and p > noise_thr. The symbol appears one clock after that strobe with sym_pol=1.
- R2: A negative peak is declared on a valid sample x when x is above p, the last unequal step into p was downward, and p < -noise_thr. It is reported with sym_pol=0.
- R3: A turning point whose magnitude is not strictly beyond noise_thr yields no symbol.
- R4: sym_larger is 1 when the peak magnitude is strictly greater than that of the previous peak of the same polarity, and 0 when it is equal or smaller. Each polarity is tracked separately.
- R5: The first peak of each polarity after reset reports sym_larger=1.
- R6: sym_interval counts the valid strobes after the previous peak-declaring strobe, up to and including the current one. Before the first peak the count starts at reset. The count saturates at 255.
- R7: sym_valid is high for exactly one cycle per declared peak. Cycles with smp_valid low are ignored: they are not counted and produce no symbol.
- R8: The matcher keeps the 8 most recent codes {pol, larger}. Reference i occupies REFS bits [16i+15:16i], with its k-th most recent code at bits [16i+2k+1:16i+2k]. match_valid pulses one cycle after sym_valid when all 8 codes equal a reference; match_idx gives the lowest matching index. The interval is ignored.
- R9: Any valid strobe on which the interval count reaches 255 empties the window. A symbol declared on that strobe becomes the first entry of the new window. No match is reported until 8 symbols have been collected again.
- R10: While and right after reset, sym_valid and match_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW (12) | Signed two's-complement sample |
| noise_thr | input | DW-1 (11) | Unsigned peak magnitude threshold |
| sym_valid | output | 1 | One-cycle pulse per peak symbol |
| sym_pol | output | 1 | 1 = positive peak, 0 = negative |
| sym_larger | output | 1 | 1 = magnitude grew vs previous same-polarity peak |
| sym_interval | output | IW (8) | Samples since previous peak, saturating |
| match_valid | output | 1 | Window equals a reference |
| match_idx | output | 2 | Lowest matching reference index |

## Verification
A wrong slope or predecessor register shows up as a missing, extra or wrongly-polarised symbol in the cycle after the turning sample. The bench therefore compares every cycle against an independent model, including cycles with idle gaps between samples. Stale per-polarity magnitudes flip sym_larger at the next peak of that polarity. A broken counter shows at once in sym_interval. A wrong window or fill count surfaces one cycle after a symbol, as a spurious or missing match, most visibly right after a silence has saturated the interval.

// File: rtl/peak_pkg.sv
package peak_pkg;
    typedef enum logic [1:0] {
        SLOPE_FLAT = 2'd0,
        SLOPE_UP   = 2'd1,
        SLOPE_DOWN = 2'd2
    } slope_e;

    typedef struct packed {
        logic pol;
        logic larger;
    } peak_code_t;

    localparam int CODE_W = $bits(peak_code_t);
endpackage

// File: rtl/peak_finder.sv
module peak_finder
    import peak_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic [DW-2:0]        thr,
    output logic                 hit,
    output logic                 hit_pol,
    output logic [DW-1:0]        hit_mag
);
    logic signed [DW-1:0] prev_q;
    logic                 have_q;
    slope_e               slope_q;

    logic signed [DW:0] thr_ext, prev_ext, mag_ext;
    logic rise_end, fall_end;

    always_comb begin
        thr_ext  = $signed({2'b00, thr});
        prev_ext = $signed({prev_q[DW-1], prev_q});
        rise_end = have_q && (slope_q == SLOPE_UP)   && (in_data < prev_q) && (prev_ext > thr_ext);
        fall_end = have_q && (slope_q == SLOPE_DOWN) && (in_data > prev_q) && (prev_ext < -thr_ext);
        hit      = in_valid && (rise_end || fall_end);
        hit_pol  = rise_end;
        mag_ext  = rise_end ? prev_ext : -prev_ext;
        hit_mag  = mag_ext[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            have_q  <= 1'b0;
            slope_q <= SLOPE_FLAT;
        end else if (in_valid) begin
            have_q <= 1'b1;
            prev_q <= in_data;
            if (have_q) begin
                if (in_data > prev_q)      slope_q <= SLOPE_UP;
                else if (in_data < prev_q) slope_q <= SLOPE_DOWN;
            end
        end
    end
endmodule

// File: rtl/peak_coder.sv
module peak_coder
    import peak_pkg::*;
#(
    parameter int DW = 12,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          hit,
    input  logic          hit_pol,
    input  logic [DW-1:0] hit_mag,
    output logic          push,
    output peak_code_t    push_code,
    output logic          hist_clear,
    output logic          sym_valid,
    output peak_code_t    sym_code,
    output logic [IW-1:0] sym_interval
);
    localparam logic [IW-1:0] CNT_MAX = {IW{1'b1}};

    logic [IW-1:0] cnt_q, cnt_nxt;
    logic [1:0]    seen_q;
    logic [DW-1:0] last_q [2];

    always_comb begin
        cnt_nxt          = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        push             = in_valid && hit;
        push_code.pol    = hit_pol;
        push_code.larger = !seen_q[hit_pol] || (hit_mag > last_q[hit_pol]);
        hist_clear       = in_valid && (cnt_nxt == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            seen_q       <= '0;
            last_q[0]    <= '0;
            last_q[1]    <= '0;
            sym_valid    <= 1'b0;
            sym_code     <= '0;
            sym_interval <= '0;
        end else begin
            sym_valid <= push;
            if (in_valid) begin
                if (hit) begin
                    cnt_q           <= '0;
                    seen_q[hit_pol] <= 1'b1;
                    last_q[hit_pol] <= hit_mag;
                    sym_code        <= push_code;
                    sym_interval    <= cnt_nxt;
                end else begin
                    cnt_q <= cnt_nxt;
                end
            end
        end
    end
endmodule

// File: rtl/code_matcher.sv
module code_matcher
    import peak_pkg::*;
#(
    parameter int NREF  = 4,
    parameter int DEPTH = 8,
    parameter logic [NREF*DEPTH*CODE_W-1:0] REFS = '0,
    localparam int IXW = (NREF > 1) ? $clog2(NREF) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  peak_code_t     push_code,
    input  logic           clear,
    output logic           match_valid,
    output logic [IXW-1:0] match_idx
);
    localparam int HW = DEPTH * CODE_W;
    localparam int FW = $clog2(DEPTH + 1);

    logic [HW-1:0]   hist_q;
    logic [FW-1:0]   fill_q;
    logic            pushed_q;
    logic [NREF-1:0] hit_vec;
    logic [IXW-1:0]  idx_c;
    logic            any_c;

    for (genvar i = 0; i < NREF; i++) begin : g_ref
        assign hit_vec[i] = (hist_q == REFS[i*HW +: HW]);
    end

    always_comb begin
        idx_c = '0;
        any_c = 1'b0;
        for (int i = NREF - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                idx_c = IXW'(i);
                any_c = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q      <= '0;
            fill_q      <= '0;
            pushed_q    <= 1'b0;
            match_valid <= 1'b0;
            match_idx   <= '0;
        end else begin
            pushed_q    <= push;
            match_valid <= pushed_q && (fill_q == FW'(DEPTH)) && any_c;
            if (pushed_q && any_c) match_idx <= idx_c;
            if (clear && push) begin
                hist_q <= HW'(push_code);
                fill_q <= FW'(1);
            end else if (clear) begin
                fill_q <= '0;
            end else if (push) begin
                hist_q <= {hist_q[HW-CODE_W-1:0], push_code};
                if (fill_q != FW'(DEPTH)) fill_q <= fill_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vowel_peak_coder.sv
module vowel_peak_coder
    import peak_pkg::*;
#(
    parameter int DW    = 12,
    parameter int IW    = 8,
    parameter int NREF  = 4,
    parameter int DEPTH = 8,
    parameter logic [NREF*DEPTH*CODE_W-1:0] REFS = 64'h8888_DDDD_2222_7777,
    localparam int IXW = (NREF > 1) ? $clog2(NREF) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_data,
    input  logic [DW-2:0]        noise_thr,
    output logic                 sym_valid,
    output logic                 sym_pol,
    output logic                 sym_larger,
    output logic [IW-1:0]        sym_interval,
    output logic                 match_valid,
    output logic [IXW-1:0]       match_idx
);
    logic          pk_hit, pk_pol;
    logic [DW-1:0] pk_mag;
    logic          push, hist_clear;
    peak_code_t    push_code, sym_code;

    peak_finder #(.DW(DW)) u_find (
        .clk(clk), .rst(rst), .in_valid(smp_valid), .in_data(smp_data),
        .thr(noise_thr), .hit(pk_hit), .hit_pol(pk_pol), .hit_mag(pk_mag)
    );

    peak_coder #(.DW(DW), .IW(IW)) u_code (
        .clk(clk), .rst(rst), .in_valid(smp_valid), .hit(pk_hit),
        .hit_pol(pk_pol), .hit_mag(pk_mag), .push(push), .push_code(push_code),
        .hist_clear(hist_clear), .sym_valid(sym_valid), .sym_code(sym_code),
        .sym_interval(sym_interval)
    );

    code_matcher #(.NREF(NREF), .DEPTH(DEPTH), .REFS(REFS)) u_match (
        .clk(clk), .rst(rst), .push(push), .push_code(push_code),
        .clear(hist_clear), .match_valid(match_valid), .match_idx(match_idx)
    );

    assign sym_pol    = sym_code.pol;
    assign sym_larger = sym_code.larger;
endmodule

// File: rtl/vowel_peak_coder_chk.sv
module vowel_peak_coder_chk #(
    parameter int IW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_valid,
    input logic          sym_valid,
    input logic [IW-1:0] sym_interval,
    input logic          match_valid
);
    // R7
    sym_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> $past(smp_valid));

    // R8
    match_after_sym_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> $past(sym_valid));

    // R6
    interval_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> (sym_interval != '0));

    // R9
    sat_blocks_match_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && (sym_interval == {IW{1'b1}})) |=> !match_valid);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sym_valid && !match_valid));
endmodule

bind vowel_peak_coder vowel_peak_coder_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .sym_valid(sym_valid),
    .sym_interval(sym_interval), .match_valid(match_valid)
);

// File: tb/vowel_peak_coder_test.sv
module vowel_peak_coder_test;
    localparam logic [63:0] TB_REFS = 64'h8888_7777_2222_7777;
    localparam int NSEG = 6;
    // amp0, delta per period, half period, periods, threshold, idle gap
    localparam int SEG [NSEG][6] = '{
        '{ 200,  20, 4, 6,   50, 0},
        '{ 400, -20, 3, 6,   50, 1},
        '{ 300,   0, 5, 6,   50, 0},
        '{  40,   0, 4, 4,   60, 0},
        '{1500, 100, 6, 5,    0, 2},
        '{2047,   0, 2, 3, 2000, 0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic signed [11:0] smp_data = '0;
    logic [10:0] noise_thr = '0;
    logic        sym_valid, sym_pol, sym_larger, match_valid;
    logic [7:0]  sym_interval;
    logic [1:0]  match_idx;

    always #2 clk = ~clk;

    vowel_peak_coder #(.REFS(TB_REFS)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .noise_thr(noise_thr), .sym_valid(sym_valid), .sym_pol(sym_pol),
        .sym_larger(sym_larger), .sym_interval(sym_interval),
        .match_valid(match_valid), .match_idx(match_idx)
    );

    int n_vec = 0, n_bad = 0, cycles = 0;
    bit done = 0;
    int sat_seen = 0;

    // independent model state
    int m_have, m_prev, m_dir, m_cnt, m_fill, m_pend, m_pend_idx, m_thr;
    int m_seen [2];
    int m_last [2];
    bit [15:0] m_hist;
    int cur;

    task automatic model_reset();
        m_have = 0; m_prev = 0; m_dir = 0; m_cnt = 0; m_fill = 0;
        m_pend = 0; m_pend_idx = 0; m_hist = '0;
        m_seen[0] = 0; m_seen[1] = 0; m_last[0] = 0; m_last[1] = 0;
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle at a falling edge, check at the next falling edge
    task automatic step(bit v, int x);
        int e_sv = 0, e_pol = 0, e_lg = 0, e_int = 0, e_mv, e_mi, nxt, pk, mag;
        e_mv = m_pend; e_mi = m_pend_idx; m_pend = 0;
        smp_valid = v; smp_data = 12'(x); noise_thr = 11'(m_thr);
        if (v) begin
            nxt = (m_cnt >= 255) ? 255 : m_cnt + 1;
            pk = 0; mag = 0;
            if (m_have && m_dir == 1 && x < m_prev && m_prev > m_thr) begin pk = 1; e_pol = 1; mag = m_prev; end
            if (m_have && m_dir == 2 && x > m_prev && m_prev < -m_thr) begin pk = 1; e_pol = 0; mag = -m_prev; end
            if (pk) begin
                e_sv = 1; e_int = nxt;
                e_lg = (!m_seen[e_pol] || mag > m_last[e_pol]) ? 1 : 0;
                m_seen[e_pol] = 1; m_last[e_pol] = mag; m_cnt = 0;
            end else m_cnt = nxt;
            if (nxt == 255 && pk) begin m_hist = 16'(e_pol*2 + e_lg); m_fill = 1; end
            else if (nxt == 255) m_fill = 0;
            else if (pk) begin
                m_hist = {m_hist[13:0], 2'(e_pol*2 + e_lg)};
                if (m_fill < 8) m_fill++;
            end
            if (pk && m_fill == 8) begin
                for (int i = 3; i >= 0; i--)
                    if (m_hist == TB_REFS[i*16 +: 16]) begin m_pend = 1; m_pend_idx = i; end
            end
            if (m_have) begin
                if (x > m_prev) m_dir = 1; else if (x < m_prev) m_dir = 2;
            end
            m_have = 1; m_prev = x;
        end
        @(negedge clk);
        chk(sym_valid == e_sv, "R1 R2 R3 R7 sym_valid", sym_valid, e_sv);
        if (e_sv && sym_valid) begin
            chk(sym_pol == e_pol, "R1 R2 sym_pol", sym_pol, e_pol);
            chk(sym_larger == e_lg, "R4 R5 sym_larger", sym_larger, e_lg);
            chk(sym_interval == e_int, "R6 sym_interval", sym_interval, e_int);
            if (e_int == 255) sat_seen++;
        end
        chk(match_valid == e_mv, "R8 R9 match_valid", match_valid, e_mv);
        if (e_mv && match_valid) chk(match_idx == e_mi, "R8 match_idx", match_idx, e_mi);
    endtask

    task automatic ramp(int tgt, int half, int gap);
        int start = cur;
        for (int k = 1; k <= half; k++) begin
            cur = start + ((tgt - start) * k) / half;
            step(1, cur);
            for (int g = 0; g < gap; g++) step(0, 12'h5A5);
        end
    endtask

    task automatic tone(int amp0, int delta, int half, int nper, int gap);
        for (int p = 0; p < nper; p++) begin
            ramp(amp0 + delta * p, half, gap);
            ramp(-(amp0 + delta * p), half, gap);
        end
    endtask

    task automatic do_reset();
        rst = 1; smp_valid = 0;
        repeat (3) @(negedge clk);
        // R10: outputs quiet during reset
        chk(!sym_valid && !match_valid, "R10 reset outputs", {sym_valid, match_valid}, 0);
        rst = 0; model_reset(); cur = 0;
    endtask

    initial begin
        model_reset(); cur = 0; m_thr = 0;
        @(negedge clk);
        do_reset();
        // table walk: growing (ref 0 and priority over duplicate ref 2), shrinking with
        // idle gaps (R7), equal sizes (R4), sub-threshold (R3), large swings
        for (int s = 0; s < NSEG; s++) begin
            m_thr = SEG[s][4];
            tone(SEG[s][0], SEG[s][1], SEG[s][2], SEG[s][3], SEG[s][5]);
        end
        // R9 / R6: long silence saturates the interval and empties the window
        m_thr = 50;
        for (int i = 0; i < 300; i++) step(1, 0);
        cur = 0;
        tone(500, 10, 4, 6, 0);
        chk(sat_seen > 0, "R6 saturated interval seen", sat_seen, 1);
        // R10 / R5: reset mid-stream, first peaks of each polarity report larger
        do_reset();
        m_thr = 10;
        tone(100, -5, 3, 3, 0);
        step(0, 0); step(0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule